// File: doc/BRIEF.md
# Completion Ring Producer with Pass Tag

This block takes completion entries of eight 32-bit words from an upstream source and writes them, one word per cycle, into a circular ring in shared memory. It keeps the head slot of that ring and a 4-bit pass tag. The tag is stamped into the top nibble of each entry's final word. A consumer polls slots and compares tags to tell fresh entries from stale ones. It does not need to read the head pointer, and checking the tag's lowest bit is enough.

An entry marked as an internal error goes to a second, smaller ring instead. There the top nibble of the final word holds the error code supplied with the entry, not the pass tag. Each ring has its own head, its own consumer tail input, its own full check and its own interrupt pulse. The memory write port is shared, and a ring-select output tells the two rings apart.

Top module: `ring_producer`

## Requirements
- R1: After reset is released, both heads read 0, both interrupts are low, no write is issued, and the block is ready after the two-cycle reset synchronisation.
- R2: An accepted entry produces exactly eight consecutive write cycles, one per word. Each write goes to address {slot, word index}, where the word index (bits 2:0) runs from 0 to 7 in order. Words 0 to 6 are written unchanged, and word 7 keeps its bits 27:0.
- R3: For the main ring, bits 31:28 of word 7 carry the pass tag. The tag is 1 for the first pass through the ring, goes up by one each time the main head wraps from the last slot to slot 0, and wraps from 15 to 0.
- R4: An entry whose error flag is set is written with the ring-select output high. Bits 31:28 of its word 7 carry the entry's error code. It does not move the main head and does not change the pass tag.
- R5: While an entry is being written, ready stays low. The next entry can be accepted in the cycle after the interrupt is raised.
- R6: A request is refused (ready low, nothing written, head unchanged) when advancing the target ring's head would make it equal to that ring's tail input.
- R7: One cycle after the last word is written, exactly one interrupt pulses for one cycle: the main interrupt for the main ring, the error interrupt for the error ring.
- R8: Each ring's head advances by one, modulo its depth, in the same cycle its interrupt is raised, and at no other time.
- R9: A full error ring does not block main-ring entries, and a full main ring does not block error entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Entry offered |
| req_ready | output | 1 | Entry accepted when high together with req_valid |
| req_words | input | 256 | Eight words, word i in bits 32*i+31:32*i |
| req_err | input | 1 | Entry is an internal error, routed to the error ring |
| req_err_code | input | 4 | Code stamped into error entries |
| main_tail | input | MAIN_SW | Consumer tail slot of the main ring |
| err_tail | input | ERR_SW | Consumer tail slot of the error ring |
| wr_en | output | 1 | Memory word write strobe |
| wr_err_ring | output | 1 | Write targets the error ring (1) or the main ring (0) |
| wr_addr | output | ADDR_W | Word address {slot, word index} |
| wr_data | output | 32 | Word written |
| main_head | output | MAIN_SW | Main ring head slot |
| err_head | output | ERR_SW | Error ring head slot |
| main_irq | output | 1 | One-cycle pulse after a main entry completes |
| err_irq | output | 1 | One-cycle pulse after an error entry completes |

## Verification
The checker watches several properties on every cycle. Word indices must step through in order, ready must stay low while writing, and each interrupt must be a single pulse that follows a last-word write to the matching ring. The main head may move only with its interrupt, an error completion must leave the main head untouched, and a full target must refuse a request. The bench scenarios cover the values that need a reference model: the exact address and data of each word, the pass tag sequence across many laps including the wrap from 15 to 0, error-code stamping, and the independence of the two full conditions.

// File: rtl/ring_prod_pkg.sv
package ring_prod_pkg;
  localparam int ENTRY_WORDS = 8;
  localparam int WORD_W      = 32;
  localparam int TAG_W       = 4;
  localparam int IDX_W       = $clog2(ENTRY_WORDS);
  localparam int ENTRY_W     = ENTRY_WORDS * WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [TAG_W-1:0]  tag_t;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int DEPTH  = 16,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [SLOT_W-1:0] tail,
  output logic [SLOT_W-1:0] head,
  output logic              full,
  output logic              wrap
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(DEPTH - 1);

  logic [SLOT_W-1:0] head_q;
  logic [SLOT_W-1:0] next_slot;

  always_comb begin
    if (head_q == LAST_SLOT) next_slot = '0;
    else                     next_slot = head_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       head_q <= '0;
    else if (advance) head_q <= next_slot;
  end

  assign head = head_q;
  assign full = (next_slot == tail);
  assign wrap = advance && (head_q == LAST_SLOT);
endmodule

// File: rtl/lap_counter.sv
module lap_counter
  import ring_prod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output tag_t tag
);
  tag_t tag_q;
  tag_t tag_d;

  always_comb tag_d = tag_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tag_q <= TAG_W'(1);
    else if (step) tag_q <= tag_d;
  end

  assign tag = tag_q;
endmodule

// File: rtl/entry_seq.sv
module entry_seq
  import ring_prod_pkg::*;
#(
  parameter int MAIN_SW = 4,
  parameter int ERR_SW  = 3,
  parameter int ADDR_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_err,
  input  logic [ENTRY_W-1:0] words_in,
  input  tag_t               code_in,
  input  tag_t               main_tag,
  input  logic [MAIN_SW-1:0] main_head,
  input  logic [ERR_SW-1:0]  err_head,
  output logic               busy,
  output logic               wr_en,
  output logic               wr_err,
  output logic [ADDR_W-1:0]  wr_addr,
  output word_t              wr_data,
  output logic               done,
  output logic               done_err
);
  localparam int SLOT_F = ADDR_W - IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_WORDS - 1);

  word_t             buf_q [ENTRY_WORDS];
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              busy_q, busy_d;
  logic              err_q;
  tag_t              code_q;
  logic              last;
  logic [SLOT_F-1:0] slot;
  word_t             cur;
  tag_t              stamp;

  for (genvar g = 0; g < ENTRY_WORDS; g++) begin : g_buf
    always_ff @(posedge clk) begin
      if (start) buf_q[g] <= words_in[g*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      err_q  <= start_err;
      code_q <= code_in;
    end
  end

  assign last = busy_q && (idx_q == LAST_IDX);

  always_comb begin
    idx_d  = idx_q;
    busy_d = busy_q;
    if (start) begin
      idx_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      idx_d = idx_q + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  always_comb begin
    if (err_q) slot = SLOT_F'(err_head);
    else       slot = SLOT_F'(main_head);
    stamp = err_q ? code_q : main_tag;
    cur   = buf_q[idx_q];
    if (idx_q == LAST_IDX) wr_data = {stamp, cur[WORD_W-TAG_W-1:0]};
    else                   wr_data = cur;
  end

  assign busy     = busy_q;
  assign wr_en    = busy_q;
  assign wr_err   = err_q;
  assign wr_addr  = {slot, idx_q};
  assign done     = last;
  assign done_err = last && err_q;
endmodule

// File: rtl/ring_producer.sv
module ring_producer
  import ring_prod_pkg::*;
#(
  parameter int MAIN_DEPTH = 16,
  parameter int ERR_DEPTH  = 8,
  localparam int MAIN_SW   = (MAIN_DEPTH > 1) ? $clog2(MAIN_DEPTH) : 1,
  localparam int ERR_SW    = (ERR_DEPTH > 1) ? $clog2(ERR_DEPTH) : 1,
  localparam int ADDR_W    = ((MAIN_SW > ERR_SW) ? MAIN_SW : ERR_SW) + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ENTRY_W-1:0] req_words,
  input  logic               req_err,
  input  logic [TAG_W-1:0]   req_err_code,
  input  logic [MAIN_SW-1:0] main_tail,
  input  logic [ERR_SW-1:0]  err_tail,
  output logic               wr_en,
  output logic               wr_err_ring,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [WORD_W-1:0]  wr_data,
  output logic [MAIN_SW-1:0] main_head,
  output logic [ERR_SW-1:0]  err_head,
  output logic               main_irq,
  output logic               err_irq
);
  logic [1:0] rst_pipe;
  logic       rst_ni;
  logic       busy, accept, done, done_err;
  logic       main_full, err_full, main_wrap, err_wrap_unused;
  logic       main_adv, err_adv;
  logic       main_irq_q, err_irq_q;
  tag_t       main_tag;

  // Reset: asserted asynchronously, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  assign req_ready = rst_ni && !busy && !(req_err ? err_full : main_full);
  assign accept    = req_valid && req_ready;
  assign main_adv  = done && !done_err;
  assign err_adv   = done_err;

  ring_ptr #(.DEPTH(MAIN_DEPTH), .SLOT_W(MAIN_SW)) u_main_ptr (
    .clk(clk), .rst_n(rst_ni), .advance(main_adv), .tail(main_tail),
    .head(main_head), .full(main_full), .wrap(main_wrap)
  );

  ring_ptr #(.DEPTH(ERR_DEPTH), .SLOT_W(ERR_SW)) u_err_ptr (
    .clk(clk), .rst_n(rst_ni), .advance(err_adv), .tail(err_tail),
    .head(err_head), .full(err_full), .wrap(err_wrap_unused)
  );

  lap_counter u_lap (
    .clk(clk), .rst_n(rst_ni), .step(main_wrap), .tag(main_tag)
  );

  entry_seq #(.MAIN_SW(MAIN_SW), .ERR_SW(ERR_SW), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_ni), .start(accept), .start_err(req_err),
    .words_in(req_words), .code_in(req_err_code), .main_tag(main_tag),
    .main_head(main_head), .err_head(err_head), .busy(busy),
    .wr_en(wr_en), .wr_err(wr_err_ring), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done), .done_err(done_err)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      main_irq_q <= 1'b0;
      err_irq_q  <= 1'b0;
    end else begin
      main_irq_q <= main_adv;
      err_irq_q  <= err_adv;
    end
  end

  assign main_irq = main_irq_q;
  assign err_irq  = err_irq_q;
endmodule

// File: rtl/ring_producer_chk.sv
module ring_producer_chk #(
  parameter int MAIN_DEPTH = 16,
  parameter int MAIN_SW    = 4,
  parameter int ERR_SW     = 3,
  parameter int ADDR_W     = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_err,
  input logic [MAIN_SW-1:0] main_tail,
  input logic               wr_en,
  input logic               wr_err_ring,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [MAIN_SW-1:0] main_head,
  input logic               main_irq,
  input logic               err_irq
);
  logic [MAIN_SW-1:0] main_nxt;
  assign main_nxt = (main_head == MAIN_SW'(MAIN_DEPTH - 1)) ? '0 : main_head + 1'b1;

  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[2:0] != 3'd7) |=> (wr_en && wr_addr[2:0] == $past(wr_addr[2:0]) + 3'd1)); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !req_ready); // R5
  AST_MAIN_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    main_irq |-> $past(wr_en && !wr_err_ring && wr_addr[2:0] == 3'd7)); // R7
  AST_ERR_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> $past(wr_en && wr_err_ring && wr_addr[2:0] == 3'd7)); // R7
  AST_MAIN_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    main_irq |=> !main_irq); // R7
  AST_ERR_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq); // R7
  AST_HEAD_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (main_head != $past(main_head)) |-> main_irq); // R8
  AST_ERR_KEEPS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> $stable(main_head)); // R4
  AST_MAIN_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_err && main_nxt == main_tail) |-> !req_ready); // R6

  always_comb begin
    if (rst_n) AST_ONE_IRQ: assert (!(main_irq && err_irq)); // R7
  end
endmodule

bind ring_producer ring_producer_chk #(
  .MAIN_DEPTH(MAIN_DEPTH), .MAIN_SW(MAIN_SW), .ERR_SW(ERR_SW), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_err(req_err), .main_tail(main_tail), .wr_en(wr_en),
  .wr_err_ring(wr_err_ring), .wr_addr(wr_addr), .main_head(main_head),
  .main_irq(main_irq), .err_irq(err_irq)
);

// File: tb/test_ring_producer.sv
module test_ring_producer;
  localparam int MD = 4;
  localparam int ED = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [255:0] req_words = '0;
  logic         req_err = 1'b0;
  logic [3:0]   req_err_code = '0;
  logic [1:0]   main_tail = '0;
  logic [0:0]   err_tail = '0;
  logic         wr_en, wr_err_ring;
  logic [4:0]   wr_addr;
  logic [31:0]  wr_data;
  logic [1:0]   main_head;
  logic [0:0]   err_head;
  logic         main_irq, err_irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [1:0] m_head = '0;
  logic [3:0] m_tag = 4'd1;
  logic [0:0] e_head = '0;
  int zero_tags = 0;

  typedef struct packed {
    logic       err;
    logic [3:0] code;
    logic [1:0] slot;
    logic [3:0] nib;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 4'h0, 2'd0, 4'h1},
    '{1'b1, 4'h5, 2'd0, 4'h5},
    '{1'b0, 4'h0, 2'd1, 4'h1},
    '{1'b0, 4'h0, 2'd2, 4'h1},
    '{1'b1, 4'hA, 2'd1, 4'hA},
    '{1'b0, 4'h0, 2'd3, 4'h1},
    '{1'b0, 4'h0, 2'd0, 4'h2},
    '{1'b1, 4'hF, 2'd0, 4'hF}
  };

  ring_producer #(.MAIN_DEPTH(MD), .ERR_DEPTH(ED)) i_ring_producer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_words(req_words), .req_err(req_err), .req_err_code(req_err_code),
    .main_tail(main_tail), .err_tail(err_tail), .wr_en(wr_en),
    .wr_err_ring(wr_err_ring), .wr_addr(wr_addr), .wr_data(wr_data),
    .main_head(main_head), .err_head(err_head), .main_irq(main_irq),
    .err_irq(err_irq)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input int id, input int w);
    return 32'hB000_0000 | 32'((id & 255) << 12) | 32'(w << 4) | 32'h3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Sends one entry and checks all eight writes, the interrupt and the head.
  task automatic run_entry(input logic err, input logic [3:0] code,
                           input logic [1:0] slot, input logic [3:0] nib, input int id);
    logic [31:0] exp_d;
    @(negedge clk);
    req_valid = 1'b1;
    req_err = err;
    req_err_code = code;
    for (int w = 0; w < 8; w++) req_words[w*32 +: 32] = pat(id, w);
    #1;
    chk(req_ready == 1'b1, "R6 ready when not full", 64'(req_ready), 64'd1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_words = '0;
    req_err_code = 4'h0;
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      exp_d = pat(id, w);
      if (w == 7) exp_d = {nib, exp_d[27:0]};
      chk(wr_en == 1'b1, "R2 write strobe", 64'(wr_en), 64'd1);
      chk(wr_addr == {slot, 3'(w)}, "R2 address", 64'(wr_addr), 64'({slot, 3'(w)}));
      chk(wr_data == exp_d, (w == 7) ? (err ? "R4 error code stamp" : "R3 pass tag stamp") : "R2 data",
          64'(wr_data), 64'(exp_d));
      chk(wr_err_ring == err, "R4 ring select", 64'(wr_err_ring), 64'(err));
      chk(req_ready == 1'b0, "R5 ready low while writing", 64'(req_ready), 64'd0);
    end
    @(negedge clk);
    chk(main_irq == !err && err_irq == err, "R7 interrupt pulse",
        64'({main_irq, err_irq}), 64'({!err, err}));
    chk(wr_en == 1'b0, "R2 exactly eight writes", 64'(wr_en), 64'd0);
    if (err) chk(err_head == ~slot[0], "R8 error head step", 64'(err_head), 64'(~slot[0]));
    else     chk(main_head == slot + 2'd1, "R8 main head step", 64'(main_head), 64'(slot + 2'd1));
    @(negedge clk);
    chk(main_irq == 1'b0 && err_irq == 1'b0, "R7 pulse one cycle", 64'({main_irq, err_irq}), 64'd0);
  endtask

  task automatic model_step(input logic err);
    if (err) e_head = e_head + 1'b1;
    else begin
      if (m_head == 2'd3) m_tag = m_tag + 4'd1;
      m_head = m_head + 2'd1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(main_head == 2'd0, "R1 main head", 64'(main_head), 64'd0);
    chk(err_head == 1'b0, "R1 error head", 64'(err_head), 64'd0);
    chk(main_irq == 1'b0 && err_irq == 1'b0, "R1 interrupts", 64'({main_irq, err_irq}), 64'd0);
    chk(wr_en == 1'b0, "R1 no write", 64'(wr_en), 64'd0);
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);

    // Table walk: R2, R3, R4
    for (int i = 0; i < 8; i++) begin
      main_tail = m_head;
      err_tail = e_head;
      run_entry(VECS[i].err, VECS[i].code, VECS[i].slot, VECS[i].nib, i);
      model_step(VECS[i].err);
    end

    // R6: main ring full refuses, nothing written
    @(negedge clk);
    main_tail = m_head + 2'd1;
    req_valid = 1'b1;
    req_err = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(req_ready == 1'b0, "R6 main full refuses", 64'(req_ready), 64'd0);
      @(negedge clk);
      chk(wr_en == 1'b0, "R6 no write when full", 64'(wr_en), 64'd0);
      chk(main_head == m_head, "R6 head unchanged when full", 64'(main_head), 64'(m_head));
    end
    req_valid = 1'b0;

    // R9: error entry accepted while main ring full
    err_tail = e_head;
    run_entry(1'b1, 4'h7, {1'b0, e_head}, 4'h7, 40);
    model_step(1'b1);

    // R6 error ring full; R9 main accepted while error ring full
    @(negedge clk);
    err_tail = e_head + 1'b1;
    req_valid = 1'b1;
    req_err = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R6 error full refuses", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(wr_en == 1'b0, "R6 no error write when full", 64'(wr_en), 64'd0);
    req_valid = 1'b0;
    main_tail = m_head;
    run_entry(1'b0, 4'h0, m_head, m_tag, 41);
    model_step(1'b0);
    chk(err_head == e_head, "R4 error head untouched by main entry", 64'(err_head), 64'(e_head));

    // R3: run enough laps to see the tag wrap 15 -> 0
    for (int n = 0; n < 66; n++) begin
      main_tail = m_head;
      err_tail = e_head;
      if (m_tag == 4'd0) zero_tags++;
      run_entry(1'b0, 4'h0, m_head, m_tag, 100 + n);
      model_step(1'b0);
    end
    chk(zero_tags > 0, "R3 tag wrapped to zero", 64'(zero_tags), 64'd1);

    finish_run();
  end
endmodule